// File: doc/BRIEF.md
# Dual Address Cycle Address-Phase Sequencer

This block is the initiator-side sequencer that opens a PCI transaction carrying a 64-bit address on a 64-bit bus. A local master asks for a transfer through one of two active-low request inputs, one for a 64-bit data width and one for a 32-bit data width. The sequencer then asks the bus arbiter for ownership and acknowledges the local side for one clock. In that clock the local side presents the address, the dual-address command on the low command nibble and the real bus command on the high nibble. The sequencer captures all of these.

Once the grant is sampled, the sequencer asserts FRAME# and drives two address phases. In the first phase the whole address appears on the AD bus, with the dual-address command on the low byte-enable nibble and the real command on the high one. In the second phase the upper address dword appears on both halves of AD, and the real command appears on both nibbles. It then gives one pulse to hand over to the data-phase logic. It keeps FRAME# and the output enable asserted until that logic reports completion, and then returns to idle.

Top module: `dac_addr_seq`

## Requirements
- R1: In idle, an asserted (low) `loc_req64_n` or `loc_req32_n` makes `loc_ack_n` and `bus_req_n` low in the next cycle. `loc_ack_n` stays low for exactly one cycle. If both requests are low, the 64-bit request wins and `wide_xfer` is 1.
- R2: A grant sampled while idle starts nothing. While the sequencer waits with the grant deasserted, `bus_req_n` stays low and `frame_n` stays high.
- R3: In the cycle after the grant is sampled low, `frame_n` is 0 and `ad_o` equals the captured 64-bit address. `cbe_o[3:0]` equals the captured low nibble, which is 4'b1101 for a dual address cycle, and `cbe_o[7:4]` equals the captured command.
- R4: In the next cycle, `ad_o[63:32]` and `ad_o[31:0]` both equal the upper address dword, and `cbe_o[7:4]` and `cbe_o[3:0]` both equal the captured command.
- R5: `bus_req_n` is high from the first address phase onward.
- R6: The address and both nibbles are captured in the cycle where `loc_ack_n` is low. Later changes on `loc_addr` and `loc_cmd` do not alter either address phase.
- R7: `ad_oe` is 1 exactly while `frame_n` is 0. When idle, and after reset, `frame_n`, `loc_ack_n` and `bus_req_n` are 1, and `ad_o`, `cbe_o`, `ad_oe` and `addr_done` are 0.
- R8: `addr_done` is 1 for exactly the cycle after the second address phase. `frame_n` stays 0 until `data_done` is sampled high, and the block is idle in the following cycle.
- R9: A 32-bit-data request gives `wide_xfer` = 0 and the same two-phase address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req64_n | input | 1 | Local request, 64-bit data, active low |
| loc_req32_n | input | 1 | Local request, 32-bit data, active low |
| loc_addr | input | 64 | Local transaction address |
| loc_cmd | input | 8 | [3:0] dual-address command, [7:4] bus command |
| loc_ack_n | output | 1 | Address acknowledge to local side, active low |
| wide_xfer | output | 1 | Captured data width, 1 = 64-bit |
| bus_req_n | output | 1 | Bus request to arbiter, active low |
| bus_gnt_n | input | 1 | Bus grant from arbiter, active low |
| frame_n | output | 1 | FRAME#, active low |
| ad_o | output | 64 | AD bus output value |
| cbe_o | output | 8 | C/BE bus output value |
| ad_oe | output | 1 | Output enable for AD and C/BE |
| addr_done | output | 1 | One-cycle handover pulse to data-phase logic |
| data_done | input | 1 | Data-phase logic finished |

## Verification
The assertions check these rules on every cycle: the output enable follows FRAME#, the acknowledge never overlaps FRAME#, a falling FRAME# always follows a sampled grant and comes with the request released, the second phase mirrors the upper dword and the command with values equal to the first phase, and the handover pulse lasts a single cycle at its fixed place. Only the bench scenarios can show that the captured address and nibbles match what the local side offered while other values sit on the inputs. The same holds for a grant that arrives early or late, for request priority, and for the return to idle with every output released.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_WAIT,
        ST_AP1,
        ST_AP2,
        ST_DATA
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       wide;
        logic       pulse;
    } ctrl_t;
endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req64_n,
    input  logic       req32_n,
    input  logic       gnt_n,
    input  logic       data_done,
    output seq_state_e state_o,
    output logic       wide_o,
    output logic       ack_n,
    output logic       bus_req_n,
    output logic       addr_done
);
    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (!req64_n || !req32_n) begin
                    ctl_d.state = ST_ACK;
                    ctl_d.wide  = !req64_n;
                end
            end
            ST_ACK:  ctl_d.state = ST_WAIT;
            ST_WAIT: if (!gnt_n) ctl_d.state = ST_AP1;
            ST_AP1:  ctl_d.state = ST_AP2;
            ST_AP2: begin
                ctl_d.state = ST_DATA;
                ctl_d.pulse = 1'b1;
            end
            ST_DATA: if (data_done) ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, wide: 1'b0, pulse: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o   = ctl_q.state;
    assign wide_o    = ctl_q.wide;
    assign ack_n     = (ctl_q.state != ST_ACK);
    assign bus_req_n = !((ctl_q.state == ST_ACK) || (ctl_q.state == ST_WAIT));
    assign addr_done = ctl_q.pulse;
endmodule

// File: rtl/dac_seq_latch.sv
module dac_seq_latch #(
    parameter int AD_W  = 64,
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [AD_W-1:0]    addr_i,
    input  logic [2*NIB_W-1:0] cmd_i,
    output logic [AD_W-1:0]    addr_o,
    output logic [2*NIB_W-1:0] cmd_o
);
    typedef struct packed {
        logic [AD_W-1:0]    addr;
        logic [2*NIB_W-1:0] cmd;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) begin
            hold_d.addr = addr_i;
            hold_d.cmd  = cmd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign addr_o = hold_q.addr;
    assign cmd_o  = hold_q.cmd;
endmodule

// File: rtl/dac_seq_drive.sv
module dac_seq_drive
    import dac_seq_pkg::*;
#(
    parameter int AD_W  = 64,
    parameter int NIB_W = 4
) (
    input  seq_state_e         state,
    input  logic [AD_W-1:0]    addr,
    input  logic [2*NIB_W-1:0] cmd,
    output logic               frame_n,
    output logic [AD_W-1:0]    ad_o,
    output logic [2*NIB_W-1:0] cbe_o,
    output logic               ad_oe
);
    localparam int HALF_W = AD_W / 2;

    logic [NIB_W-1:0]  cmd_lo, cmd_hi;
    logic [HALF_W-1:0] addr_hi;

    assign cmd_lo  = cmd[NIB_W-1:0];
    assign cmd_hi  = cmd[2*NIB_W-1:NIB_W];
    assign addr_hi = addr[AD_W-1:HALF_W];

    always_comb begin
        frame_n = 1'b1;
        ad_oe   = 1'b0;
        ad_o    = '0;
        cbe_o   = '0;
        unique case (state)
            ST_AP1: begin
                frame_n = 1'b0;
                ad_oe   = 1'b1;
                ad_o    = addr;
                cbe_o   = {cmd_hi, cmd_lo};
            end
            ST_AP2: begin
                frame_n = 1'b0;
                ad_oe   = 1'b1;
                ad_o    = {addr_hi, addr_hi};
                cbe_o   = {cmd_hi, cmd_hi};
            end
            ST_DATA: begin
                frame_n = 1'b0;
                ad_oe   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dac_addr_seq.sv
module dac_addr_seq
    import dac_seq_pkg::*;
#(
    parameter int AD_W  = 64,
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_req64_n,
    input  logic               loc_req32_n,
    input  logic [AD_W-1:0]    loc_addr,
    input  logic [2*NIB_W-1:0] loc_cmd,
    output logic               loc_ack_n,
    output logic               wide_xfer,
    output logic               bus_req_n,
    input  logic               bus_gnt_n,
    output logic               frame_n,
    output logic [AD_W-1:0]    ad_o,
    output logic [2*NIB_W-1:0] cbe_o,
    output logic               ad_oe,
    output logic               addr_done,
    input  logic               data_done
);
    seq_state_e         state;
    logic [AD_W-1:0]    addr_q;
    logic [2*NIB_W-1:0] cmd_q;

    dac_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req64_n   (loc_req64_n),
        .req32_n   (loc_req32_n),
        .gnt_n     (bus_gnt_n),
        .data_done (data_done),
        .state_o   (state),
        .wide_o    (wide_xfer),
        .ack_n     (loc_ack_n),
        .bus_req_n (bus_req_n),
        .addr_done (addr_done)
    );

    dac_seq_latch #(.AD_W(AD_W), .NIB_W(NIB_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state == ST_ACK),
        .addr_i  (loc_addr),
        .cmd_i   (loc_cmd),
        .addr_o  (addr_q),
        .cmd_o   (cmd_q)
    );

    dac_seq_drive #(.AD_W(AD_W), .NIB_W(NIB_W)) u_drive (
        .state   (state),
        .addr    (addr_q),
        .cmd     (cmd_q),
        .frame_n (frame_n),
        .ad_o    (ad_o),
        .cbe_o   (cbe_o),
        .ad_oe   (ad_oe)
    );
endmodule

// File: rtl/dac_addr_seq_chk.sv
module dac_addr_seq_chk #(
    parameter int AD_W  = 64,
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               loc_ack_n,
    input logic               bus_req_n,
    input logic               bus_gnt_n,
    input logic               frame_n,
    input logic [AD_W-1:0]    ad_o,
    input logic [2*NIB_W-1:0] cbe_o,
    input logic               ad_oe,
    input logic               addr_done
);
    localparam int HALF_W = AD_W / 2;

    p_oe_follows_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe == !frame_n);

    p_ack_not_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!loc_ack_n && !frame_n));

    p_frame_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> $past(!bus_gnt_n) && !$past(bus_req_n));

    p_req_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> bus_req_n);

    p_second_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |=> (ad_o[AD_W-1:HALF_W] == ad_o[HALF_W-1:0])
            && (ad_o[AD_W-1:HALF_W] == $past(ad_o[AD_W-1:HALF_W]))
            && (cbe_o[2*NIB_W-1:NIB_W] == cbe_o[NIB_W-1:0])
            && (cbe_o[2*NIB_W-1:NIB_W] == $past(cbe_o[2*NIB_W-1:NIB_W])));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> !addr_done);

    p_done_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> !frame_n && $past(!frame_n) && $past(!frame_n, 2) && $past(frame_n, 3));
endmodule

bind dac_addr_seq dac_addr_seq_chk #(.AD_W(AD_W), .NIB_W(NIB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_ack_n (loc_ack_n),
    .bus_req_n (bus_req_n),
    .bus_gnt_n (bus_gnt_n),
    .frame_n   (frame_n),
    .ad_o      (ad_o),
    .cbe_o     (cbe_o),
    .ad_oe     (ad_oe),
    .addr_done (addr_done)
);

// File: tb/dac_addr_seq_tb.sv
module dac_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] DAC_NIB = 4'b1101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_req64_n = 1'b1, loc_req32_n = 1'b1;
    logic [63:0] loc_addr = '0;
    logic [7:0]  loc_cmd = '0;
    logic        loc_ack_n, wide_xfer, bus_req_n, frame_n, ad_oe, addr_done;
    logic        bus_gnt_n = 1'b1, data_done = 1'b0;
    logic [63:0] ad_o;
    logic [7:0]  cbe_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .loc_req64_n(loc_req64_n), .loc_req32_n(loc_req32_n),
        .loc_addr(loc_addr), .loc_cmd(loc_cmd),
        .loc_ack_n(loc_ack_n), .wide_xfer(wide_xfer),
        .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n),
        .frame_n(frame_n), .ad_o(ad_o), .cbe_o(cbe_o), .ad_oe(ad_oe),
        .addr_done(addr_done), .data_done(data_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_outputs(input string tag);
        chk({tag, " frame_n"}, 64'(frame_n), 64'd1);
        chk({tag, " ack_n"}, 64'(loc_ack_n), 64'd1);
        chk({tag, " bus_req_n"}, 64'(bus_req_n), 64'd1);
        chk({tag, " ad_oe"}, 64'(ad_oe), 64'd0);
        chk({tag, " ad_o"}, ad_o, 64'd0);
        chk({tag, " cbe_o"}, 64'(cbe_o), 64'd0);
        chk({tag, " addr_done"}, 64'(addr_done), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        idle_outputs("R7 reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle_grant();
        bus_gnt_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 idle grant frame_n", 64'(frame_n), 64'd1);
            chk("R2 idle grant bus_req_n", 64'(bus_req_n), 64'd1);
        end
        bus_gnt_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_run(input bit use64, input bit both, input logic [63:0] addr,
                         input logic [3:0] cmd, input int gnt_wait);
        logic [31:0] hi = addr[63:32];
        if (use64 || both) loc_req64_n = 1'b0;
        if (!use64 || both) loc_req32_n = 1'b0;
        @(negedge clk);
        chk("R1 ack_n low", 64'(loc_ack_n), 64'd0);
        chk("R1 bus_req_n low", 64'(bus_req_n), 64'd0);
        chk("R1 R9 wide_xfer", 64'(wide_xfer), 64'(use64 || both));
        loc_addr = addr;
        loc_cmd  = {cmd, DAC_NIB};
        loc_req64_n = 1'b1;
        loc_req32_n = 1'b1;
        @(negedge clk);
        chk("R1 ack_n one cycle", 64'(loc_ack_n), 64'd1);
        loc_addr = ~addr;
        loc_cmd  = {~cmd, 4'h0};
        for (int i = 0; i < gnt_wait; i++) begin
            chk("R2 waiting bus_req_n", 64'(bus_req_n), 64'd0);
            chk("R2 waiting frame_n", 64'(frame_n), 64'd1);
            @(negedge clk);
        end
        bus_gnt_n = 1'b0;
        @(negedge clk);
        bus_gnt_n = 1'b1;
        chk("R3 ap1 frame_n", 64'(frame_n), 64'd0);
        chk("R3 R6 ap1 ad_o", ad_o, addr);
        chk("R3 ap1 cbe_o dac", 64'(cbe_o[3:0]), 64'(DAC_NIB));
        chk("R3 R6 ap1 cbe_o cmd", 64'(cbe_o[7:4]), 64'(cmd));
        chk("R5 ap1 bus_req_n", 64'(bus_req_n), 64'd1);
        chk("R7 ap1 ad_oe", 64'(ad_oe), 64'd1);
        @(negedge clk);
        chk("R4 ap2 ad_o", ad_o, {hi, hi});
        chk("R4 ap2 cbe_o", 64'(cbe_o), 64'({cmd, cmd}));
        chk("R8 ap2 no done", 64'(addr_done), 64'd0);
        @(negedge clk);
        chk("R8 done pulse", 64'(addr_done), 64'd1);
        chk("R8 frame held", 64'(frame_n), 64'd0);
        @(negedge clk);
        chk("R8 done ends", 64'(addr_done), 64'd0);
        chk("R8 frame held 2", 64'(frame_n), 64'd0);
        chk("R7 oe held", 64'(ad_oe), 64'd1);
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
        idle_outputs("R7 R8 back to idle");
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_grant();
        t_run(1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0, 4'h6, 0);
        t_run(1'b0, 1'b0, 64'hFEDC_BA98_0000_0004, 4'h7, 3);
        t_run(1'b1, 1'b1, 64'h8000_0001_7FFF_FFFC, 4'hC, 1);
        t_run(1'b0, 1'b0, 64'h0000_0001_FFFF_FFF0, 4'hE, 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule